// File: doc/BRIEF.md
# Palette Loader and Colour Lookup

This block takes a palette burst delivered as 32-bit words by a fetch stream, unpacks each word into two 16-bit entries and writes them into a 256-entry lookup RAM. The first entry of a burst carries a depth code in its top nibble. That code sets the pixel depth and also sets how many words make up the burst. When the last expected word has been taken, the block raises a one-cycle "palette loaded" pulse.

After the load, a stream of pixel values is mapped to 12-bit RGB (4 bits per colour). At 8 bpp or less, the low bits of the pixel value select a palette entry. At 12 or 16 bpp the RAM is bypassed, and the top four bits of each colour field of the pixel pass straight through. Memory fetching and raster timing belong to other blocks.

Top module: `pal_lut`

## Requirements
- R1: After reset, `pal_loaded` and `rgb_valid` are low, `rgb` is zero, no burst is in progress, and the depth code is 3 (8 bpp).
- R2: A high `load_start` begins a new burst and restarts the word count, even in the middle of a burst. A word presented in the same cycle is dropped. The depth code is taken from bits 15:12 of the first accepted word, and only from that word.
- R3: A burst is 9 words long when the depth code is 4. For any other code it is 129 words long.
- R4: `pal_loaded` is high for exactly one cycle, in the cycle after the final word of a burst is accepted.
- R5: A word presented while no burst is in progress changes neither the palette, the depth code nor `pal_loaded`.
- R6: Word k of a burst writes bits 11:0 of its low half to entry 2k and bits 27:16 to entry 2k+1. Entries above 255 are discarded. Each entry holds red in bits 11:8, green in bits 7:4 and blue in bits 3:0.
- R7: At 8 bpp or less, the entry index is the pixel value masked by depth: code 0 uses bit 0, code 1 uses bits 1:0, code 2 uses bits 3:0, and code 3 or any code of 5 or above uses bits 7:0.
- R8: With depth code 4, `rgb` = {pix[15:12], pix[10:7], pix[4:1]}. The pixel is read as RGB565 and the palette is not used.
- R9: `rgb_valid` follows `pix_valid` with one cycle of latency. `rgb` is computed with the depth code and palette contents as they stood in the cycle the pixel was presented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_start | input | 1 | Begin a new palette burst |
| word_valid | input | 1 | Palette word present |
| word_data | input | 32 | Palette word, two entries, low half first |
| pix_valid | input | 1 | Pixel value present |
| pix_data | input | 16 | Palette index or RGB565 pixel |
| rgb_valid | output | 1 | Mapped pixel present |
| rgb | output | 12 | Mapped pixel, R[11:8] G[7:4] B[3:0] |
| pal_loaded | output | 1 | One-cycle pulse at the end of a burst |

## Verification
A wrong word count shows on the `pal_loaded` pulse: it arrives early or late compared with a model that counts 9 or 129 accepted words. The error is visible in the very cycle the pulse should or should not appear. A corrupt palette entry or a bad depth code cannot be seen until a pixel reaches that entry. For that reason, every load is followed by a sweep of all 256 index values, with junk in the masked-off bits, and each `rgb` is compared one cycle after its pixel. A write to the wrong half-word shows up as neighbouring entries that have swapped places.

// File: rtl/pal_lut.sv
module pal_lut #(
  parameter int ENTRIES     = 256,
  parameter int SHORT_WORDS = 9,
  parameter int LONG_WORDS  = 129,
  parameter logic [3:0] BYPASS_CODE = 4'd4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load_start,
  input  logic        word_valid,
  input  logic [31:0] word_data,
  input  logic        pix_valid,
  input  logic [15:0] pix_data,
  output logic        rgb_valid,
  output logic [11:0] rgb,
  output logic        pal_loaded
);
  localparam int IW = $clog2(ENTRIES);
  localparam int CW = $clog2(LONG_WORDS);

  logic [11:0]   ram [ENTRIES];
  logic [CW-1:0] cnt;
  logic          loading;
  logic [3:0]    code;

  wire [3:0]    hdr    = (cnt == '0) ? word_data[15:12] : code;
  wire [CW-1:0] last   = (hdr == BYPASS_CODE) ? CW'(SHORT_WORDS - 1) : CW'(LONG_WORDS - 1);
  wire          accept = word_valid && loading && !load_start;
  wire [CW:0]   a0     = {cnt, 1'b0};
  wire [CW:0]   a1     = a0 + 1'b1;

  always_ff @(posedge clk) begin
    if (accept) begin
      if (int'(a0) < ENTRIES) ram[a0[IW-1:0]] <= word_data[11:0];
      if (int'(a1) < ENTRIES) ram[a1[IW-1:0]] <= word_data[27:16];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      loading    <= 1'b0;
      cnt        <= '0;
      code       <= 4'd3;
      pal_loaded <= 1'b0;
    end else begin
      pal_loaded <= 1'b0;
      if (load_start) begin
        loading <= 1'b1;
        cnt     <= '0;
      end else if (accept) begin
        if (cnt == '0) code <= word_data[15:12];
        if (cnt == last) begin
          loading    <= 1'b0;
          pal_loaded <= 1'b1;
        end
        cnt <= cnt + 1'b1;
      end
    end
  end

  logic [IW-1:0] idx;
  always_comb begin
    case (code)
      4'd0:    idx = IW'(pix_data[0]);
      4'd1:    idx = IW'(pix_data[1:0]);
      4'd2:    idx = IW'(pix_data[3:0]);
      default: idx = pix_data[IW-1:0];
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rgb_valid <= 1'b0;
      rgb       <= '0;
    end else begin
      rgb_valid <= pix_valid;
      if (pix_valid)
        rgb <= (code == BYPASS_CODE) ? {pix_data[15:12], pix_data[10:7], pix_data[4:1]}
                                     : ram[idx];
    end
  end

  assert_pulse_one_cycle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pal_loaded |=> !pal_loaded);
  assert_pulse_ends_burst_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pal_loaded |-> ($past(loading) && !loading));
  assert_count_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    loading |-> (int'(cnt) < LONG_WORDS));
  assert_idle_ignore_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!loading && !load_start) |=> ($stable(cnt) && $stable(code) && !pal_loaded));
  assert_valid_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |=> rgb_valid);
  assert_valid_drops_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_valid |=> !rgb_valid);
endmodule

// File: tb/tb_pal_lut.sv
module tb_pal_lut;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic load_start = 1'b0, word_valid = 1'b0, pix_valid = 1'b0;
  logic [31:0] word_data = '0;
  logic [15:0] pix_data = '0;
  logic rgb_valid, pal_loaded;
  logic [11:0] rgb;

  always #2.5 clk = ~clk;

  pal_lut dut (.clk(clk), .rst_n(rst_n), .load_start(load_start), .word_valid(word_valid),
               .word_data(word_data), .pix_valid(pix_valid), .pix_data(pix_data),
               .rgb_valid(rgb_valid), .rgb(rgb), .pal_loaded(pal_loaded));

  int checks = 0, errors = 0, pulses = 0, cycles = 0;
  string tag = "R1";

  logic [11:0] m_ram [256];
  int m_cnt = 0, m_code = 3;
  bit m_loading = 0, e_loaded = 0, e_rv = 0;
  logic [11:0] e_rgb = '0;

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      m_cnt = 0; m_code = 3; m_loading = 0; e_loaded = 0; e_rv = 0; e_rgb = '0;
    end else begin
      int idx;
      e_loaded = 0;
      e_rv = pix_valid;
      if (pix_valid) begin
        if (m_code == 4) e_rgb = {pix_data[15:12], pix_data[10:7], pix_data[4:1]};
        else begin
          case (m_code)
            0: idx = pix_data % 2;
            1: idx = pix_data % 4;
            2: idx = pix_data % 16;
            default: idx = pix_data % 256;
          endcase
          e_rgb = m_ram[idx];
        end
      end
      if (load_start) begin
        m_loading = 1; m_cnt = 0;
      end else if (word_valid && m_loading) begin
        if (m_cnt == 0) m_code = word_data[15:12];
        if (2*m_cnt < 256) m_ram[2*m_cnt] = word_data[11:0];
        if (2*m_cnt+1 < 256) m_ram[2*m_cnt+1] = word_data[27:16];
        m_cnt++;
        if (m_cnt == ((m_code == 4) ? 9 : 129)) begin
          m_loading = 0; e_loaded = 1;
        end
      end
    end
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && cycles > 1) begin
      chk({"R4 loaded ", tag}, pal_loaded, e_loaded);
      chk({"R9 valid ", tag}, rgb_valid, e_rv);
      if (e_rv) chk({"rgb ", tag}, rgb, e_rgb);
      if (pal_loaded) pulses++;
    end
  end

  task automatic step(bit ls, bit wv, logic [31:0] wd, bit pv, logic [15:0] pd);
    @(negedge clk);
    load_start = ls; word_valid = wv; word_data = wd; pix_valid = pv; pix_data = pd;
  endtask

  task automatic burst(int code, int nwords, int seed);
    step(1, 0, 0, 0, 0);
    for (int k = 0; k < nwords; k++) begin
      logic [15:0] lo, hi;
      lo = 16'((k*37 + seed*13 + 5) & 16'hffff);
      hi = 16'((k*91 + seed*7 + 11) & 16'hffff);
      if (k == 0) lo[15:12] = 4'(code);
      step(0, 1, {hi, lo}, 0, 0);
      if (k % 3 == 2) step(0, 0, 0, 0, 0);
    end
    repeat (3) step(0, 0, 0, 0, 0);
  endtask

  task automatic sweep(int seed);
    for (int i = 0; i < 256; i++) step(0, 0, 0, 1, 16'((i*257 + seed*4099) & 16'hffff));
    repeat (2) step(0, 0, 0, 0, 0);
  endtask

  initial begin
    int p0;
    repeat (4) @(negedge clk);
    tag = "R1";
    chk("R1 loaded", pal_loaded, 0);
    chk("R1 valid", rgb_valid, 0);
    chk("R1 rgb", rgb, 0);
    rst_n = 1'b1;
    repeat (2) step(0, 0, 0, 0, 0);

    tag = "R2 R3 R6 R7 8bpp"; p0 = pulses;
    burst(3, 129, 1);
    chk("R3 one pulse per burst", pulses - p0, 1);
    sweep(0);

    tag = "R5 idle words";
    for (int k = 0; k < 6; k++) step(0, 1, 32'h4fff_4fff, 0, 0);
    repeat (2) step(0, 0, 0, 0, 0);
    chk("R5 no pulse on idle words", pulses - p0, 1);
    sweep(1);

    tag = "R7 4bpp"; burst(2, 129, 2); sweep(2);
    tag = "R7 2bpp"; burst(1, 129, 3); sweep(3);
    tag = "R7 1bpp"; burst(0, 129, 4); sweep(4);

    tag = "R8 R3 bypass"; p0 = pulses;
    burst(4, 9, 5);
    chk("R3 short burst pulse", pulses - p0, 1);
    for (int k = 0; k < 4; k++) step(0, 1, 32'h1234_3abc, 0, 0);
    sweep(5);

    tag = "R2 restart"; p0 = pulses;
    step(1, 0, 0, 0, 0);
    for (int k = 0; k < 50; k++) step(0, 1, 32'h0aaa_0000 | k, 0, 0);
    step(1, 1, 32'h1555_4000, 0, 0);
    for (int k = 0; k < 129; k++) step(0, 1, {16'(k*3), (k == 0) ? 16'h7123 : 16'(k*5)}, 0, 0);
    repeat (3) step(0, 0, 0, 0, 0);
    chk("R2 restart single pulse", pulses - p0, 1);
    sweep(6);

    repeat (3) step(0, 0, 0, 0, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(5ns * 150000);
    errors++; checks++;
    $display("FAIL watchdog actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule